// File: doc/BRIEF.md
# CDS Sampling Clock Timing Generator

This block drives the three sampling clocks of a four-channel correlated-double-sampling image front end. The clocks are the reset-sample clock, the video-sample clock and the converter clock. All three are derived from one fast system clock. Each pixel period lasts eight converter half-periods, which gives four full converter cycles per pixel, one for each channel conversion. Inside that period, one reset-sample pulse and one video-sample pulse are placed at tick positions that the user programs.

The edge positions arrive as tick counts on configuration inputs. A combinational checker compares them against the ordering and guard-band rules between the three clocks, and drives `cfg_err_o` whenever any rule would be broken. The sequence starts only from a clean configuration. It stops only on a pixel boundary, either when `run_i` drops or when the configuration turns bad. A one-tick pixel strobe marks the rise of the reset-sample clock. The configuration is captured at the start of every period, so a change made in the middle of a period takes effect at the next boundary.

Top module: `cds_clk_gen`

## Requirements
- R1: Within a running period of P = 8*H ticks (H = `half_i`), `conv_clk_o` is high at ticks [0,H), [2H,3H), [4H,5H) and [6H,7H), and low at all other ticks.
- R2: `rst_clk_o` is high exactly at ticks t with `rst_rise_i` <= t < `rst_fall_i`.
- R3: `vid_clk_o` is high exactly at ticks t with `vid_rise_i` <= t < `vid_fall_i`.
- R4: `pix_stb_o` is high for one system clock, at tick `rst_rise_i` of each running period.
- R5: During reset and while idle, all four clock/strobe outputs are 0. When `run_i` is sampled high at a rising edge with no configuration error, tick 0 appears right after that edge.
- R6: Dropping `run_i` ends generation only after the last tick of the current period; all outputs then stay 0.
- R7: `cfg_err_o` is 1 in any of these cases: 8*H < MIN_PIX; H < MIN_CPW; the order rst_rise < rst_fall <= vid_rise < vid_fall < P fails; either sample pulse is shorter than MIN_SPW ticks.
- R8: `cfg_err_o` is also 1 in any of these cases: vid_rise does not lie in a converter low phase at least G_RISE ticks before the next converter rise; vid_fall is not at least G_FALL ticks before the next converter fall; a sample falling edge lands fewer than KEEP ticks after any converter edge.
- R9: No period starts while `cfg_err_o` is 1. An error present at the last tick of a period stops generation, even with `run_i` high.
- R10: The configuration is captured at each period start. An input change made mid-period first shows in the following period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock, one tick |
| rst_ni | input | 1 | asynchronous reset, active low |
| run_i | input | 1 | run request, acted on at pixel boundaries |
| half_i | input | 5 | converter half-period in ticks (H) |
| rst_rise_i | input | 8 | reset-sample rise tick |
| rst_fall_i | input | 8 | reset-sample fall tick |
| vid_rise_i | input | 8 | video-sample rise tick |
| vid_fall_i | input | 8 | video-sample fall tick |
| cfg_err_o | output | 1 | configuration breaks a timing rule |
| rst_clk_o | output | 1 | reset-sample clock |
| vid_clk_o | output | 1 | video-sample clock |
| conv_clk_o | output | 1 | converter clock |
| pix_stb_o | output | 1 | pixel start strobe |

## Verification
`cfg_err_o` is combinational, so the bench checks it one step after the configuration inputs change, with no clock edge in between. The clock outputs are decoded from registered state. Tick 0 therefore shows in the cycle after the edge that samples `run_i`, and each later tick shows one cycle after the one before it. The driver sets `run_i` just after a falling edge and queues one expected item per following cycle. The monitor pops one item at every falling edge, so each item lines up with its tick. Stops and mid-period changes are queued as full old-configuration periods followed by idle items, which checks the boundary behaviour tick by tick.

// File: rtl/cds_clk_pkg.sv
package cds_clk_pkg;
  localparam int unsigned TICK_W = 8;
  localparam int unsigned HALF_W = TICK_W - 3;

  typedef logic [TICK_W-1:0] tick_t;
  typedef logic [HALF_W-1:0] half_t;

  typedef struct packed {
    half_t half;
    tick_t rst_rise;
    tick_t rst_fall;
    tick_t vid_rise;
    tick_t vid_fall;
  } edge_cfg_t;
endpackage

// File: rtl/cds_cfg_check.sv
module cds_cfg_check
  import cds_clk_pkg::*;
#(
  parameter int unsigned MIN_PIX = 34,
  parameter int unsigned MIN_CPW = 4,
  parameter int unsigned MIN_SPW = 3,
  parameter int unsigned G_RISE  = 1,
  parameter int unsigned G_FALL  = 4,
  parameter int unsigned KEEP    = 2,
  parameter int unsigned G_GAP   = 1
) (
  input  edge_cfg_t cfg_i,
  output logic      err_o
);
  localparam int unsigned W = TICK_W + 2;
  localparam logic [W-1:0] MIN_PIX_W = W'(MIN_PIX);
  localparam logic [W-1:0] MIN_CPW_W = W'(MIN_CPW);
  localparam logic [W-1:0] MIN_SPW_W = W'(MIN_SPW);
  localparam logic [W-1:0] G_RISE_W  = W'(G_RISE);
  localparam logic [W-1:0] G_FALL_W  = W'(G_FALL);
  localparam logic [W-1:0] KEEP_W    = W'(KEEP);
  localparam logic [W-1:0] G_GAP_W   = W'(G_GAP);

  logic [W-1:0] h, per, rr, rf, vr, vf, e, lo;
  logic bad_len, bad_ord, bad_pw, bad_gap, rise_ok, fall_ok, keep_bad;

  always_comb begin
    h   = W'(cfg_i.half);
    per = h << 3;
    rr  = W'(cfg_i.rst_rise);
    rf  = W'(cfg_i.rst_fall);
    vr  = W'(cfg_i.vid_rise);
    vf  = W'(cfg_i.vid_fall);

    bad_len = (per < MIN_PIX_W) || (h < MIN_CPW_W);
    bad_ord = !((rr < rf) && (rf <= vr) && (vr < vf) && (vf < per));
    bad_pw  = ((rf - rr) < MIN_SPW_W) || ((vf - vr) < MIN_SPW_W);
    bad_gap = (per + rr - vf) < G_GAP_W;

    // video rise must sit in a low phase, G_RISE before the next rise
    rise_ok = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if ((h * W'(2*k+1) <= vr) && (vr + G_RISE_W <= h * W'(2*k+2))) rise_ok = 1'b1;
    end

    // video fall must lead the next converter fall by G_FALL (j=4 wraps)
    fall_ok = 1'b0;
    for (int j = 0; j < 5; j++) begin
      lo = (j == 0) ? '0 : h * W'(2*j-1);
      if ((lo <= vf) && (vf + G_FALL_W <= h * W'(2*j+1))) fall_ok = 1'b1;
    end

    // keep-out after every converter edge
    keep_bad = 1'b0;
    for (int n = 0; n < 8; n++) begin
      e = h * W'(n);
      if ((rf >= e) && (rf < e + KEEP_W)) keep_bad = 1'b1;
      if ((vf >= e) && (vf < e + KEEP_W)) keep_bad = 1'b1;
    end

    err_o = bad_len | bad_ord | bad_pw | bad_gap | !rise_ok | !fall_ok | keep_bad;
  end
endmodule

// File: rtl/cds_seq_ctr.sv
module cds_seq_ctr
  import cds_clk_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      run_i,
  input  logic      err_i,
  input  edge_cfg_t cfg_i,
  output logic      run_o,
  output tick_t     tick_o,
  output logic      ph_lo_o,
  output logic      last_o,
  output edge_cfg_t shd_o
);
  logic      run_q;
  tick_t     tick_q;
  half_t     sub_q;
  logic [2:0] ph_q;
  edge_cfg_t shd_q;
  tick_t     per_m1;
  logic      wrap, go, sub_last;

  assign per_m1   = {shd_q.half, 3'b000} - TICK_W'(1);
  assign wrap     = run_q && (tick_q == per_m1);
  assign sub_last = (sub_q == shd_q.half - HALF_W'(1));
  assign go       = (!run_q || wrap) && run_i && !err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      tick_q <= '0;
      sub_q  <= '0;
      ph_q   <= '0;
      shd_q  <= '0;
    end else if (go) begin
      run_q  <= 1'b1;
      tick_q <= '0;
      sub_q  <= '0;
      ph_q   <= '0;
      shd_q  <= cfg_i;
    end else if (wrap) begin
      run_q  <= 1'b0;
      tick_q <= '0;
      sub_q  <= '0;
      ph_q   <= '0;
    end else if (run_q) begin
      tick_q <= tick_q + TICK_W'(1);
      if (sub_last) begin
        sub_q <= '0;
        ph_q  <= ph_q + 3'd1;
      end else begin
        sub_q <= sub_q + HALF_W'(1);
      end
    end
  end

  assign run_o   = run_q;
  assign tick_o  = tick_q;
  assign ph_lo_o = ph_q[0];
  assign last_o  = wrap;
  assign shd_o   = shd_q;
endmodule

// File: rtl/cds_edge_dec.sv
module cds_edge_dec
  import cds_clk_pkg::*;
(
  input  logic      run_i,
  input  tick_t     tick_i,
  input  logic      ph_lo_i,
  input  edge_cfg_t shd_i,
  output logic      rst_clk_o,
  output logic      vid_clk_o,
  output logic      conv_clk_o,
  output logic      pix_stb_o
);
  always_comb begin
    conv_clk_o = run_i && !ph_lo_i;
    rst_clk_o  = run_i && (tick_i >= shd_i.rst_rise) && (tick_i < shd_i.rst_fall);
    vid_clk_o  = run_i && (tick_i >= shd_i.vid_rise) && (tick_i < shd_i.vid_fall);
    pix_stb_o  = run_i && (tick_i == shd_i.rst_rise);
  end
endmodule

// File: rtl/cds_clk_gen.sv
module cds_clk_gen
  import cds_clk_pkg::*;
#(
  parameter int unsigned MIN_PIX = 34,
  parameter int unsigned MIN_CPW = 4,
  parameter int unsigned MIN_SPW = 3,
  parameter int unsigned G_RISE  = 1,
  parameter int unsigned G_FALL  = 4,
  parameter int unsigned KEEP    = 2,
  parameter int unsigned G_GAP   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic [TICK_W-1:0] rst_rise_i,
  input  logic [TICK_W-1:0] rst_fall_i,
  input  logic [TICK_W-1:0] vid_rise_i,
  input  logic [TICK_W-1:0] vid_fall_i,
  output logic              cfg_err_o,
  output logic              rst_clk_o,
  output logic              vid_clk_o,
  output logic              conv_clk_o,
  output logic              pix_stb_o
);
  edge_cfg_t cfg_w, shd_w;
  tick_t     tick_w;
  logic      run_w, ph_lo_w, last_w;

  assign cfg_w = '{half: half_i, rst_rise: rst_rise_i, rst_fall: rst_fall_i,
                   vid_rise: vid_rise_i, vid_fall: vid_fall_i};

  cds_cfg_check #(
    .MIN_PIX(MIN_PIX), .MIN_CPW(MIN_CPW), .MIN_SPW(MIN_SPW),
    .G_RISE(G_RISE), .G_FALL(G_FALL), .KEEP(KEEP), .G_GAP(G_GAP)
  ) u_check (
    .cfg_i(cfg_w),
    .err_o(cfg_err_o)
  );

  cds_seq_ctr u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .err_i  (cfg_err_o),
    .cfg_i  (cfg_w),
    .run_o  (run_w),
    .tick_o (tick_w),
    .ph_lo_o(ph_lo_w),
    .last_o (last_w),
    .shd_o  (shd_w)
  );

  cds_edge_dec u_dec (
    .run_i     (run_w),
    .tick_i    (tick_w),
    .ph_lo_i   (ph_lo_w),
    .shd_i     (shd_w),
    .rst_clk_o (rst_clk_o),
    .vid_clk_o (vid_clk_o),
    .conv_clk_o(conv_clk_o),
    .pix_stb_o (pix_stb_o)
  );
endmodule

// File: rtl/cds_clk_gen_chk.sv
module cds_clk_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic run_w,
  input logic last_w,
  input logic cfg_err_o,
  input logic rst_clk_o,
  input logic vid_clk_o,
  input logic conv_clk_o,
  input logic pix_stb_o
);
  a_r4_stb_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_stb_o |=> !pix_stb_o);

  a_r5_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_w |-> !(conv_clk_o || rst_clk_o || vid_clk_o || pix_stb_o));

  a_r6_stop_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_w) |-> $past(last_w));

  a_r9_no_start_on_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_w) |-> $past(!cfg_err_o));

  a_r7_samples_disjoint: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rst_clk_o && vid_clk_o));

  a_r8_vid_rise_conv_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vid_clk_o) |-> !conv_clk_o);
endmodule

bind cds_clk_gen cds_clk_gen_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .run_w     (run_w),
  .last_w    (last_w),
  .cfg_err_o (cfg_err_o),
  .rst_clk_o (rst_clk_o),
  .vid_clk_o (vid_clk_o),
  .conv_clk_o(conv_clk_o),
  .pix_stb_o (pix_stb_o)
);

// File: tb/cds_clk_gen_bench.sv
module cds_clk_gen_bench;
  localparam int CLK_P = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       run_i = 1'b0;
  logic [4:0] half_i;
  logic [7:0] rst_rise_i, rst_fall_i, vid_rise_i, vid_fall_i;
  logic       cfg_err_o, rst_clk_o, vid_clk_o, conv_clk_o, pix_stb_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [3:0] expq[$];

  always #(CLK_P/2) clk_i = ~clk_i;

  cds_clk_gen u_cds_clk_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .half_i(half_i),
    .rst_rise_i(rst_rise_i), .rst_fall_i(rst_fall_i),
    .vid_rise_i(vid_rise_i), .vid_fall_i(vid_fall_i),
    .cfg_err_o(cfg_err_o), .rst_clk_o(rst_clk_o), .vid_clk_o(vid_clk_o),
    .conv_clk_o(conv_clk_o), .pix_stb_o(pix_stb_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_cfg(input int h, input int rr, input int rf, input int vr, input int vf);
    half_i = 5'(h); rst_rise_i = 8'(rr); rst_fall_i = 8'(rf);
    vid_rise_i = 8'(vr); vid_fall_i = 8'(vf);
  endtask

  // expected item per tick: {conv, rst, vid, stb}
  task automatic push_period(input int h, input int rr, input int rf, input int vr, input int vf);
    for (int t = 0; t < 8*h; t++)
      expq.push_back({((t / h) % 2) == 0, (t >= rr) && (t < rf), (t >= vr) && (t < vf), t == rr});
  endtask

  task automatic push_idle(input int n);
    for (int i = 0; i < n; i++) expq.push_back(4'b0000);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
    #1;
  endtask

  task automatic drain();
    while (expq.size() > 0) @(negedge clk_i);
    #1;
  endtask

  task automatic chk_err(input string req, input logic exp);
    #1;
    chk(req, cfg_err_o, exp);
  endtask

  // monitor: one expected item per cycle
  always @(negedge clk_i) begin
    if (expq.size() > 0) begin
      logic [3:0] e;
      e = expq.pop_front();
      chk("R1 conv_clk", conv_clk_o, e[3]);
      chk("R2 rst_clk",  rst_clk_o,  e[2]);
      chk("R3 vid_clk",  vid_clk_o,  e[1]);
      chk("R4 pix_stb",  pix_stb_o,  e[0]);
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    set_cfg(6, 2, 5, 7, 10);
    step(3);
    // R5: quiet in reset
    chk("R5 reset conv", conv_clk_o, 1'b0);
    chk("R5 reset rst", rst_clk_o, 1'b0);
    chk("R5 reset vid", vid_clk_o, 1'b0);
    chk("R5 reset stb", pix_stb_o, 1'b0);
    rst_ni = 1'b1;
    chk_err("R7 legal cfg", 1'b0);

    // R5/R6: start, three periods, stop mid third period
    step(1);
    push_idle(0);
    push_period(6, 2, 5, 7, 10);
    push_period(6, 2, 5, 7, 10);
    push_period(6, 2, 5, 7, 10);
    push_idle(6);
    run_i = 1'b1;
    step(100);
    run_i = 1'b0;
    drain();

    // R7: static rule checks
    set_cfg(3, 2, 5, 7, 10); chk_err("R7 short period", 1'b1);
    set_cfg(6, 2, 4, 7, 10); chk_err("R7 short rst pulse", 1'b1);
    set_cfg(6, 2, 5, 4, 10); chk_err("R7 order vid before rst fall", 1'b1);
    set_cfg(6, 2, 5, 7, 9);  chk_err("R7 short vid pulse", 1'b1);
    // R8: converter-relative rules
    set_cfg(6, 1, 4, 5, 10); chk_err("R8 vid rise in conv high", 1'b1);
    set_cfg(6, 2, 5, 7, 13); chk_err("R8 vid fall in keep-out", 1'b1);
    set_cfg(6, 2, 5, 7, 15); chk_err("R8 vid fall too near conv fall", 1'b1);
    set_cfg(6, 2, 7, 8, 11); chk_err("R8 rst fall in keep-out", 1'b1);
    set_cfg(6, 2, 5, 11, 14); chk_err("R8 legal edge-tight cfg", 1'b0);

    // R9: no start with bad configuration
    set_cfg(6, 2, 5, 5, 10);
    step(1);
    push_idle(20);
    run_i = 1'b1;
    drain();
    run_i = 1'b0;

    // R10: mid-period change lands in next period
    set_cfg(6, 2, 5, 7, 10);
    step(1);
    push_period(6, 2, 5, 7, 10);
    push_period(6, 2, 5, 7, 11);
    push_idle(4);
    run_i = 1'b1;
    step(10);
    vid_fall_i = 8'd11;
    step(60);
    run_i = 1'b0;
    drain();

    // R9: error arising mid-run stops at boundary despite run_i
    set_cfg(6, 2, 5, 7, 10);
    step(1);
    push_period(6, 2, 5, 7, 10);
    push_idle(8);
    run_i = 1'b1;
    step(10);
    vid_rise_i = 8'd5;
    drain();
    run_i = 1'b0;

    // R4: strobe at tick 0
    set_cfg(6, 0, 3, 7, 10);
    chk_err("R4 cfg with rst at tick 0", 1'b0);
    step(1);
    push_period(6, 0, 3, 7, 10);
    push_idle(4);
    run_i = 1'b1;
    step(20);
    run_i = 1'b0;
    drain();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule